// File: doc/BRIEF.md
# Dual-Lane Synchronous Serial Port

This block moves words between a parallel core and two serial data lanes, A and B. Both lanes always point the same way, so one instance is either a two-lane transmitter or a two-lane receiver. A system that needs traffic in both directions at once uses two instances. A single configuration bit sets the direction. On the parallel side, each lane has its own valid/ready word channel. Every serial bit is timed by one serial clock cycle. The serial clock is either divided down from the system clock or taken from an external pin. The frame sync is either generated internally from a second divider or sampled from a pin.

The port has two framing modes. In the first, the frame sync marks every word. In the second, the frame sync marks only the first word of a block, and the following words run back to back with no gap until the programmed count is reached. The configuration inputs are expected to stay static while `enable` is high. Dropping `enable` returns the port to idle and clears its sticky error flags.

Top module: `dual_lane_serial_port`

## Requirements
- R1: While `enable` is low, `data_oe`, `sclk_oe`, `fs_oe`, both `rx_*_valid`, both `tx_*_ready`, `underflow` and `overflow` are all 0, and the flags and held words are cleared.
- R2: `cfg_dir_tx`=1 drives both lanes (`data_oe`=1 when enabled). `cfg_dir_tx`=0 makes both lanes receive (`data_oe`=0), and `tx_*_ready` never rises in that mode.
- R3: Lanes A and B carry independent words inside the same frame, each word taken from and delivered to its own parallel channel.
- R4: With `cfg_clk_int`=1, `sclk_out` has a period of 2*(`cfg_clk_div`+1) system clocks and `sclk_oe`=1. With `cfg_clk_int`=0, `sclk_out` stays 0, `sclk_oe`=0, and bits are timed by `sclk_in`.
- R5: With `cfg_fs_int`=1, `fs_out` pulses high for exactly one serial clock cycle once every `cfg_fs_div`+1 serial clock cycles, and `fs_oe`=1.
- R6: `cfg_fs_late`=0 places the internal frame pulse one serial cycle before the first bit. `cfg_fs_late`=1 makes the pulse coincide with the first bit. An external frame sync is always taken as sampled high one bit before the first bit.
- R7: The word length is `cfg_word_len`+1 bits, legal from 3 to 32.
- R8: `cfg_lsb_first`=0 shifts the most significant bit first. `cfg_lsb_first`=1 shifts the least significant bit first. Received words are right-aligned either way.
- R9: `cfg_clk_pol`=0 changes transmit data on the rising serial clock edge and samples receive data on the falling edge. `cfg_clk_pol`=1 swaps the two edges.
- R10: In receive mode, a completed word appears on `rx_*_data` with `rx_*_valid`=1. It stays there until the cycle in which `rx_*_ready`=1.
- R11: With `cfg_fs_block`=1, one frame sync starts `cfg_block_last`+1 words that follow back to back. A frame sync seen before the last bit of the block is ignored.
- R12: In transmit mode, when a word slot begins and the lane has no valid word, the lane sends its previous word again and sets its sticky `underflow` bit (bit 0 is lane A, bit 1 is lane B).
- R13: In receive mode, when a new word completes while the previous one is still unread, the new word replaces it and the lane's sticky `overflow` bit is set (bit 0 is lane A, bit 1 is lane B).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Port runs when high; low returns to idle |
| cfg_dir_tx | input | 1 | 1: both lanes transmit, 0: both lanes receive |
| cfg_clk_int | input | 1 | 1: internal divided serial clock, 0: external |
| cfg_clk_pol | input | 1 | Selects the driving serial clock edge |
| cfg_fs_int | input | 1 | 1: internal frame sync, 0: external |
| cfg_fs_late | input | 1 | Internal frame pulse coincides with first bit |
| cfg_fs_block | input | 1 | 1: frame sync starts a block of words |
| cfg_lsb_first | input | 1 | Bit order select |
| cfg_word_len | input | 5 | Word length minus one |
| cfg_clk_div | input | 16 | Serial clock half period minus one, in system clocks |
| cfg_fs_div | input | 16 | Frame period minus one, in serial clocks |
| cfg_block_last | input | 8 | Words per block minus one |
| sclk_in | input | 1 | External serial clock |
| sclk_out | output | 1 | Internal serial clock |
| sclk_oe | output | 1 | Drive enable for the serial clock pin |
| fs_in | input | 1 | External frame sync |
| fs_out | output | 1 | Internal frame sync |
| fs_oe | output | 1 | Drive enable for the frame sync pin |
| da_in | input | 1 | Lane A serial input |
| db_in | input | 1 | Lane B serial input |
| da_out | output | 1 | Lane A serial output |
| db_out | output | 1 | Lane B serial output |
| data_oe | output | 1 | Drive enable shared by both data pins |
| tx_a_valid | input | 1 | Lane A transmit word valid |
| tx_a_ready | output | 1 | Lane A transmit word accepted this cycle |
| tx_a_data | input | 32 | Lane A transmit word |
| tx_b_valid | input | 1 | Lane B transmit word valid |
| tx_b_ready | output | 1 | Lane B transmit word accepted this cycle |
| tx_b_data | input | 32 | Lane B transmit word |
| rx_a_valid | output | 1 | Lane A received word pending |
| rx_a_ready | input | 1 | Lane A received word read |
| rx_a_data | output | 32 | Lane A received word |
| rx_b_valid | output | 1 | Lane B received word pending |
| rx_b_ready | input | 1 | Lane B received word read |
| rx_b_data | output | 32 | Lane B received word |
| underflow | output | 2 | Sticky transmit underflow per lane |
| overflow | output | 2 | Sticky receive overflow per lane |

## Verification
The stimulus table crosses bit order, clock polarity and early or late framing with word lengths of 3, 8, 12, 16, 24 and 32 bits. A design that aligns the shift register wrongly for short or full-width words, or that drives and samples on the same edge, returns corrupted words in those cases. Block framing is checked for three words with no frame pulse between them; a design that re-waits for the frame sync after each word would lose the block's timing. The bench also starves the transmitter to check that the previous word is repeated and the flag is set. It leaves received words unread to check that the newest word wins and the overflow flag latches, and it receives a 5-bit least-significant-first word from an external clock and frame sync, where a misplaced alignment shift would show directly.

// File: rtl/dual_lane_serial_port.sv
module dual_lane_serial_port #(
  parameter int MAX_W = 32,
  parameter int DIV_W = 16,
  parameter int BLK_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     enable,
  input  logic                     cfg_dir_tx,
  input  logic                     cfg_clk_int,
  input  logic                     cfg_clk_pol,
  input  logic                     cfg_fs_int,
  input  logic                     cfg_fs_late,
  input  logic                     cfg_fs_block,
  input  logic                     cfg_lsb_first,
  input  logic [$clog2(MAX_W)-1:0] cfg_word_len,
  input  logic [DIV_W-1:0]         cfg_clk_div,
  input  logic [DIV_W-1:0]         cfg_fs_div,
  input  logic [BLK_W-1:0]         cfg_block_last,
  input  logic                     sclk_in,
  output logic                     sclk_out,
  output logic                     sclk_oe,
  input  logic                     fs_in,
  output logic                     fs_out,
  output logic                     fs_oe,
  input  logic                     da_in,
  input  logic                     db_in,
  output logic                     da_out,
  output logic                     db_out,
  output logic                     data_oe,
  input  logic                     tx_a_valid,
  output logic                     tx_a_ready,
  input  logic [MAX_W-1:0]         tx_a_data,
  input  logic                     tx_b_valid,
  output logic                     tx_b_ready,
  input  logic [MAX_W-1:0]         tx_b_data,
  output logic                     rx_a_valid,
  input  logic                     rx_a_ready,
  output logic [MAX_W-1:0]         rx_a_data,
  output logic                     rx_b_valid,
  input  logic                     rx_b_ready,
  output logic [MAX_W-1:0]         rx_b_data,
  output logic [1:0]               underflow,
  output logic [1:0]               overflow
);
  localparam int LW = $clog2(MAX_W);

  // serial clock: internal divider or synchronised external pin
  logic [DIV_W-1:0] div_cnt;
  logic             sclk_q;
  logic [2:0]       ext_s;
  logic             tgl, rise, fall, drv_ev, smp_ev;

  assign tgl = enable && cfg_clk_int && (div_cnt == cfg_clk_div);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      div_cnt <= '0;
      sclk_q  <= 1'b0;
      ext_s   <= '0;
    end else begin
      ext_s <= {ext_s[1:0], sclk_in};
      if (!(enable && cfg_clk_int)) begin
        div_cnt <= '0;
        sclk_q  <= 1'b0;
      end else if (tgl) begin
        div_cnt <= '0;
        sclk_q  <= ~sclk_q;
      end else begin
        div_cnt <= div_cnt + DIV_W'(1);
      end
    end

  assign rise   = cfg_clk_int ? (tgl && !sclk_q) : (enable && ext_s[1] && !ext_s[2]);
  assign fall   = cfg_clk_int ? (tgl && sclk_q)  : (enable && !ext_s[1] && ext_s[2]);
  assign drv_ev = cfg_clk_pol ? fall : rise;
  assign smp_ev = cfg_clk_pol ? rise : fall;

  // frame sync
  logic [DIV_W-1:0] fs_cnt;
  logic             fs_q, fs_smp, fs_zero, start_req;

  assign fs_zero = (fs_cnt == '0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      fs_cnt <= '0;
      fs_q   <= 1'b0;
      fs_smp <= 1'b0;
    end else begin
      if (!enable || !cfg_fs_int) begin
        fs_cnt <= '0;
        fs_q   <= 1'b0;
      end else if (drv_ev) begin
        fs_q   <= fs_zero;
        fs_cnt <= (fs_cnt == cfg_fs_div) ? '0 : fs_cnt + DIV_W'(1);
      end
      if (!enable)     fs_smp <= 1'b0;
      else if (smp_ev) fs_smp <= fs_in;
    end

  assign start_req = cfg_fs_int ? (cfg_fs_late ? fs_zero : fs_q) : fs_smp;

  // shared framing state
  logic             active;
  logic [LW-1:0]    bit_idx;
  logic [BLK_W-1:0] word_idx;
  logic             last_bit, last_word, begin_frame, next_word, load, rx_done;

  assign last_bit    = (bit_idx == cfg_word_len);
  assign last_word   = !cfg_fs_block || (word_idx == cfg_block_last);
  assign begin_frame = drv_ev && start_req && (!active || (last_bit && last_word));
  assign next_word   = drv_ev && !begin_frame && active && last_bit && !last_word;
  assign load        = begin_frame || next_word;
  assign rx_done     = smp_ev && active && last_bit && !cfg_dir_tx;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      active   <= 1'b0;
      bit_idx  <= '0;
      word_idx <= '0;
    end else if (!enable) begin
      active   <= 1'b0;
      bit_idx  <= '0;
      word_idx <= '0;
    end else if (begin_frame) begin
      active   <= 1'b1;
      bit_idx  <= '0;
      word_idx <= '0;
    end else if (next_word) begin
      bit_idx  <= '0;
      word_idx <= word_idx + BLK_W'(1);
    end else if (drv_ev && active) begin
      if (last_bit) active  <= 1'b0;
      else          bit_idx <= bit_idx + LW'(1);
    end

  // alignment between word and shift register
  logic [LW-1:0]    pad;
  logic [MAX_W-1:0] keep;
  assign pad  = LW'(MAX_W - 1) - cfg_word_len;
  assign keep = {MAX_W{1'b1}} >> pad;

  logic [1:0]       tx_v, tx_r, din, dout, rx_v, rx_r, uf, of;
  logic [MAX_W-1:0] tx_d [2];
  logic [MAX_W-1:0] rx_d [2];

  assign tx_v    = {tx_b_valid, tx_a_valid};
  assign rx_r    = {rx_b_ready, rx_a_ready};
  assign din     = {db_in, da_in};
  assign tx_d[0] = tx_a_data;
  assign tx_d[1] = tx_b_data;

  for (genvar g = 0; g < 2; g++) begin : g_lane
    logic [MAX_W-1:0] sh, held, src, rsh, rsh_nx, rword, rd;
    logic             rv, ufl, ofl;

    assign src    = tx_v[g] ? tx_d[g] : held;
    assign rsh_nx = cfg_lsb_first ? {din[g], rsh[MAX_W-1:1]} : {rsh[MAX_W-2:0], din[g]};
    assign rword  = cfg_lsb_first ? (rsh_nx >> pad) : (rsh_nx & keep);

    assign tx_r[g] = load && cfg_dir_tx;
    assign dout[g] = cfg_dir_tx && active && (cfg_lsb_first ? sh[0] : sh[MAX_W-1]);
    assign rx_v[g] = rv;
    assign rx_d[g] = rd;
    assign uf[g]   = ufl;
    assign of[g]   = ofl;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        sh <= '0; held <= '0; rsh <= '0; rd <= '0;
        rv <= 1'b0; ufl <= 1'b0; ofl <= 1'b0;
      end else if (!enable) begin
        sh <= '0; held <= '0; rsh <= '0; rd <= '0;
        rv <= 1'b0; ufl <= 1'b0; ofl <= 1'b0;
      end else begin
        if (load && cfg_dir_tx) begin
          sh <= cfg_lsb_first ? src : (src << pad);
          if (tx_v[g]) held <= tx_d[g];
          else         ufl  <= 1'b1;
        end else if (drv_ev && active) begin
          sh <= cfg_lsb_first ? (sh >> 1) : (sh << 1);
        end
        if (smp_ev && active && !cfg_dir_tx) rsh <= rsh_nx;
        if (rx_done) begin
          rd <= rword;
          rv <= 1'b1;
          if (rv && !rx_r[g]) ofl <= 1'b1;
        end else if (rx_r[g]) begin
          rv <= 1'b0;
        end
      end
  end

  assign sclk_out   = sclk_q;
  assign sclk_oe    = enable && cfg_clk_int;
  assign fs_out     = fs_q;
  assign fs_oe      = enable && cfg_fs_int;
  assign data_oe    = enable && cfg_dir_tx;
  assign da_out     = dout[0];
  assign db_out     = dout[1];
  assign tx_a_ready = tx_r[0];
  assign tx_b_ready = tx_r[1];
  assign rx_a_valid = rx_v[0];
  assign rx_b_valid = rx_v[1];
  assign rx_a_data  = rx_d[0];
  assign rx_b_data  = rx_d[1];
  assign underflow  = uf;
  assign overflow   = of;
endmodule

module dual_lane_serial_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       enable,
  input logic       cfg_dir_tx,
  input logic       cfg_clk_int,
  input logic       cfg_fs_int,
  input logic       sclk_out,
  input logic       fs_out,
  input logic       tx_a_ready,
  input logic       tx_b_ready,
  input logic       rx_a_valid,
  input logic       rx_a_ready,
  input logic       rx_b_valid,
  input logic       rx_b_ready,
  input logic [1:0] underflow,
  input logic [1:0] overflow
);
  // R1
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!rx_a_valid && !rx_b_valid && underflow == 2'b00 && overflow == 2'b00));

  // R2
  rx_mode_no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_dir_tx |-> (!tx_a_ready && !tx_b_ready));

  // R4
  ext_clk_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_clk_int |=> !sclk_out);

  // R5
  ext_fs_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(enable && cfg_fs_int) |=> !fs_out);

  // R10
  rx_a_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && rx_a_valid && !rx_a_ready) |=> (rx_a_valid || !enable));

  // R10
  rx_b_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && rx_b_valid && !rx_b_ready) |=> (rx_b_valid || !enable));

  // R12
  underflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && underflow[0]) |=> (underflow[0] || !enable));

  // R13
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && overflow[0]) |=> (overflow[0] || !enable));
endmodule

bind dual_lane_serial_port dual_lane_serial_port_chk i_chk (.*);

// File: tb/test_dual_lane_serial_port.sv
module test_dual_lane_serial_port;
  localparam int CLK_PERIOD = 10;

  logic clk, rst_n, enable;
  logic cfg_dir_tx, cfg_clk_int, cfg_clk_pol, cfg_fs_int, cfg_fs_late, cfg_fs_block, cfg_lsb_first;
  logic [4:0]  cfg_word_len;
  logic [15:0] cfg_clk_div, cfg_fs_div;
  logic [7:0]  cfg_block_last;
  logic sclk_in, sclk_out, sclk_oe, fs_in, fs_out, fs_oe;
  logic da_in, db_in, da_out, db_out, data_oe;
  logic tx_a_valid, tx_a_ready, tx_b_valid, tx_b_ready;
  logic [31:0] tx_a_data, tx_b_data, rx_a_data, rx_b_data;
  logic rx_a_valid, rx_a_ready, rx_b_valid, rx_b_ready;
  logic [1:0] underflow, overflow;

  dual_lane_serial_port i_dual_lane_serial_port (.*);

  int n_tests = 0;
  int n_fail  = 0;

  // lsb, pol, late, len-1, word A, word B
  localparam logic [71:0] VEC [6] = '{
    {1'b0, 1'b0, 1'b0, 5'd7,  32'h000000A5, 32'h0000003C},
    {1'b1, 1'b0, 1'b0, 5'd15, 32'h00001234, 32'h0000BEEF},
    {1'b0, 1'b1, 1'b1, 5'd31, 32'hDEADBEEF, 32'h01234567},
    {1'b1, 1'b1, 1'b1, 5'd2,  32'h00000005, 32'h00000002},
    {1'b0, 1'b0, 1'b1, 5'd11, 32'h00000ABC, 32'h000005A5},
    {1'b1, 1'b1, 1'b0, 5'd23, 32'h00C0FFEE, 32'h0013579B}
  };

  logic [31:0] qa [8];
  logic [31:0] qb [8];
  int take_a = 0, take_b = 0, base_a = 0, base_b = 0, qn = 0;

  assign tx_a_valid = (take_a - base_a) < qn;
  assign tx_b_valid = (take_b - base_b) < qn;
  assign tx_a_data  = qa[(take_a - base_a) & 7];
  assign tx_b_data  = qb[(take_b - base_b) & 7];

  always @(posedge clk) begin
    if (tx_a_valid && tx_a_ready) take_a <= take_a + 1;
    if (tx_b_valid && tx_b_ready) take_b <= take_b + 1;
  end

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic queue_words(input int n);
    base_a = take_a;
    base_b = take_b;
    qn = n;
  endtask

  task automatic wait_smp(input logic pol);
    if (pol) @(posedge sclk_out);
    else     @(negedge sclk_out);
    #1;
  endtask

  task automatic grab(input int len, input logic lsb, input logic pol, input logic late,
                      input int nw, output logic [31:0] wa [4], output logic [31:0] wb [4],
                      output int xfs);
    xfs = 0;
    do wait_smp(pol); while (!fs_out);
    if (!late) wait_smp(pol);
    for (int w = 0; w < nw; w++) begin
      wa[w] = '0;
      wb[w] = '0;
      for (int i = 0; i < len; i++) begin
        if (w > 0 || i > 0) wait_smp(pol);
        if ((w > 0 || i > 0 || !late) && fs_out) xfs++;
        if (lsb) begin
          wa[w][i] = da_out;
          wb[w][i] = db_out;
        end else begin
          wa[w][len-1-i] = da_out;
          wb[w][len-1-i] = db_out;
        end
      end
    end
  endtask

  task automatic ext_bit(input logic f, input logic a, input logic b);
    sclk_in = 1'b1; fs_in = f; da_in = a; db_in = b;
    #(5 * CLK_PERIOD);
    sclk_in = 1'b0;
    #(5 * CLK_PERIOD);
  endtask

  task automatic ext_frame(input int len, input logic lsb, input logic [31:0] a, input logic [31:0] b);
    ext_bit(1'b1, 1'b0, 1'b0);
    for (int i = 0; i < len; i++) begin
      if (lsb) ext_bit(1'b0, a[i], b[i]);
      else     ext_bit(1'b0, a[len-1-i], b[len-1-i]);
    end
    ext_bit(1'b0, 1'b0, 1'b0);
  endtask

  task automatic idle_cfg();
    enable = 0; cfg_dir_tx = 1; cfg_clk_int = 1; cfg_clk_pol = 0; cfg_fs_int = 1;
    cfg_fs_late = 0; cfg_fs_block = 0; cfg_lsb_first = 0; cfg_word_len = 5'd7;
    cfg_clk_div = 16'd1; cfg_fs_div = 16'd9; cfg_block_last = 8'd0;
    qn = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] wa [4];
    logic [31:0] wb [4];
    logic [71:0] e;
    int xfs, len;
    time t0, t1, t2;

    rst_n = 0; sclk_in = 0; fs_in = 0; da_in = 0; db_in = 0;
    rx_a_ready = 0; rx_b_ready = 0;
    for (int i = 0; i < 8; i++) begin qa[i] = '0; qb[i] = '0; end
    idle_cfg();
    tick(3);
    rst_n = 1;
    tick(3);

    // R1: idle state
    chk("R1 data_oe", {31'd0, data_oe}, 32'd0);
    chk("R1 sclk_oe/fs_oe", {30'd0, sclk_oe, fs_oe}, 32'd0);
    chk("R1 rx valid", {30'd0, rx_a_valid, rx_b_valid}, 32'd0);
    chk("R1 tx ready", {30'd0, tx_a_ready, tx_b_ready}, 32'd0);
    chk("R1 flags", {28'd0, underflow, overflow}, 32'd0);

    // R3 R6 R7 R8 R9: table walk, per-word framing, internal clock and frame
    for (int v = 0; v < 6; v++) begin
      e = VEC[v];
      idle_cfg();
      cfg_lsb_first = e[71]; cfg_clk_pol = e[70]; cfg_fs_late = e[69]; cfg_word_len = e[68:64];
      len = int'(e[68:64]) + 1;
      cfg_fs_div = 16'(len + 1);
      qa[0] = e[63:32]; qb[0] = e[31:0];
      queue_words(1);
      enable = 1;
      grab(len, e[71], e[70], e[69], 1, wa, wb, xfs);
      chk($sformatf("R3 R6 R7 R8 R9 vec%0d lane A", v), wa[0], e[63:32]);
      chk($sformatf("R3 R6 R7 R8 R9 vec%0d lane B", v), wb[0], e[31:0]);
      enable = 0;
      tick(4);
    end

    // R4 R2: internal clock rate and output enables
    idle_cfg();
    cfg_clk_div = 16'd2;
    enable = 1;
    tick(1);
    chk("R2 data_oe in transmit", {31'd0, data_oe}, 32'd1);
    chk("R4 sclk_oe", {31'd0, sclk_oe}, 32'd1);
    @(posedge sclk_out); t0 = $time;
    @(posedge sclk_out); t1 = $time;
    chk("R4 sclk period", 32'((t1 - t0) / CLK_PERIOD), 32'd6);
    enable = 0;
    tick(4);

    // R5 R12: frame period/width, starved transmitter
    idle_cfg();
    cfg_fs_div = 16'd9;
    enable = 1;
    @(posedge fs_out); t0 = $time;
    @(negedge fs_out); t1 = $time;
    @(posedge fs_out); t2 = $time;
    #1;
    chk("R5 fs_oe", {31'd0, fs_oe}, 32'd1);
    chk("R5 fs width", 32'((t1 - t0) / CLK_PERIOD), 32'd4);
    chk("R5 fs period", 32'((t2 - t0) / CLK_PERIOD), 32'd40);
    chk("R12 underflow with no words", {30'd0, underflow}, 32'd3);
    enable = 0;
    tick(4);

    // R11: block framing, three words after one frame sync
    idle_cfg();
    cfg_fs_block = 1; cfg_block_last = 8'd2; cfg_fs_div = 16'd40;
    qa[0] = 32'h11; qa[1] = 32'h22; qa[2] = 32'h33;
    qb[0] = 32'h44; qb[1] = 32'h55; qb[2] = 32'h66;
    queue_words(3);
    enable = 1;
    grab(8, 1'b0, 1'b0, 1'b0, 3, wa, wb, xfs);
    chk("R11 block word0 A", wa[0], 32'h11);
    chk("R11 block word1 A", wa[1], 32'h22);
    chk("R11 block word2 A", wa[2], 32'h33);
    chk("R11 block word2 B", wb[2], 32'h66);
    chk("R11 no frame pulse inside block", 32'(xfs), 32'd0);
    chk("R12 no underflow when fed", {30'd0, underflow}, 32'd0);
    enable = 0;
    tick(4);

    // R12: repeat of last word
    idle_cfg();
    qa[0] = 32'h81; qb[0] = 32'h42;
    queue_words(1);
    enable = 1;
    grab(8, 1'b0, 1'b0, 1'b0, 1, wa, wb, xfs);
    chk("R12 first word A", wa[0], 32'h81);
    chk("R12 flag clear after fed word", {30'd0, underflow}, 32'd0);
    grab(8, 1'b0, 1'b0, 1'b0, 1, wa, wb, xfs);
    chk("R12 repeated word A", wa[0], 32'h81);
    chk("R12 repeated word B", wb[0], 32'h42);
    chk("R12 underflow set", {30'd0, underflow}, 32'd3);
    enable = 0;
    tick(4);

    // R10 R2: receive with external clock and frame sync
    idle_cfg();
    cfg_dir_tx = 0; cfg_clk_int = 0; cfg_fs_int = 0;
    enable = 1;
    tick(2);
    chk("R2 data_oe in receive", {31'd0, data_oe}, 32'd0);
    chk("R4 R5 external oe", {30'd0, sclk_oe, fs_oe}, 32'd0);
    ext_frame(8, 1'b0, 32'h96, 32'h3C);
    tick(2);
    chk("R10 rx valid", {30'd0, rx_a_valid, rx_b_valid}, 32'd3);
    chk("R10 rx data A", rx_a_data, 32'h96);
    chk("R10 R3 rx data B", rx_b_data, 32'h3C);
    rx_a_ready = 1; rx_b_ready = 1;
    tick(1);
    rx_a_ready = 0; rx_b_ready = 0;
    tick(1);
    chk("R10 rx valid cleared by read", {30'd0, rx_a_valid, rx_b_valid}, 32'd0);

    // R13: overflow
    ext_frame(8, 1'b0, 32'h11, 32'h22);
    ext_frame(8, 1'b0, 32'h33, 32'h44);
    tick(2);
    chk("R13 overflow set", {30'd0, overflow}, 32'd3);
    chk("R13 newest word kept A", rx_a_data, 32'h33);
    chk("R13 newest word kept B", rx_b_data, 32'h44);
    enable = 0;
    tick(2);
    chk("R1 flags cleared by disable", {28'd0, underflow, overflow}, 32'd0);

    // R7 R8: 5-bit lsb-first receive
    cfg_word_len = 5'd4; cfg_lsb_first = 1;
    enable = 1;
    tick(2);
    ext_frame(5, 1'b1, 32'h13, 32'h0A);
    tick(2);
    chk("R7 R8 lsb-first rx A", rx_a_data, 32'h13);
    chk("R7 R8 lsb-first rx B", rx_b_data, 32'h0A);
    enable = 0;
    tick(2);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule